// File: doc/BRIEF.md
# SPI Command Master with Post-Opcode Gap

This block is an SPI master that moves a whole command frame of one or more bytes while chip select stays asserted. It is meant for slaves whose command decoder cannot keep up at the fast clock rate: after the first byte (the opcode, usually ORed with a register start address), the block holds the clock at its idle level for a programmable number of system-clock cycles. It then sends the second byte (typically the number of registers to access, minus one) and every later byte back to back. The gap is inserted only in the fast configuration. When the slow configuration is selected, the frame runs with no gap.

A frame is started with a one-cycle `start` strobe that carries the byte count, the gap enable and the rate selection. The block takes transmit bytes from `tx_data` and acknowledges each one with `tx_take`, so that the source can present the next byte. Each received byte comes back on `rx_data` with a one-cycle `rx_valid`. `busy` covers the whole frame, and `done` pulses once as chip select returns high. The bus uses SPI mode 1: the clock idles low, MOSI changes on the rising edge, MISO is sampled on the falling edge, and bits go most significant first.

The timing is set by parameters counted in system-clock cycles: a half period for the fast rate, a half period for the slow rate, and the gap length. With a 64 MHz system clock, the defaults give 8 MHz and 4 MHz SCLK and a gap of 1.5 µs. That gap delays the end of the second byte by more than 1.46 µs.

Top module: `spi_gap_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `cs_n` is 1 and `sclk` is 0. Right after reset, `mosi`, `busy` and `done` are 0.
- R2: MOSI changes only on a rising SCLK edge, or when `cs_n` returns high. Each transmit byte appears on MOSI most significant bit first, one bit for each SCLK period.
- R3: MISO is sampled at each falling SCLK edge. After the eighth falling edge of a byte, `rx_data` holds that byte (first sampled bit in bit 7) with `rx_valid` high for one cycle, in frame order.
- R4: `cs_n` stays low for the whole frame. The first rising SCLK edge comes one half period after `cs_n` falls, and `cs_n` rises one half period after the last falling edge.
- R5: Each SCLK high phase, and each low phase between bits, lasts HALF_FAST cycles when `slow_mode` was 0 at start, and HALF_SLOW cycles when it was 1.
- R6: When `gap_en`=1, `slow_mode`=0 and the byte count is at least 2, the low phase between the last falling edge of byte 0 and the first rising edge of byte 1 is HALF_FAST+GAP_CYCLES cycles. SCLK stays at 0 during that phase.
- R7: Every other inter-byte low phase lasts exactly one half period. When `slow_mode`=1 or `gap_en`=0, no gap appears anywhere in the frame.
- R8: `tx_data` is captured on the start cycle and at the end of each byte that is not the last. `tx_take` pulses for one cycle after each capture, exactly `byte_count` times per frame.
- R9: A start while `busy` is high is ignored: the frame in progress keeps its byte count and no second frame follows. A start with `byte_count`=0 is also ignored.
- R10: `done` is high for exactly one cycle per frame, in the cycle in which `cs_n` has just returned to 1 and `busy` has just dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle frame request |
| byte_count | input | CNT_W | Number of bytes in the frame (0 is ignored) |
| gap_en | input | 1 | Request the post-opcode gap (applies in fast mode only) |
| slow_mode | input | 1 | 1 selects the slow SCLK rate |
| tx_data | input | 8 | Next byte to transmit |
| tx_take | output | 1 | Pulse: `tx_data` was captured and the next byte may be presented |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Pulse: `rx_data` holds a new byte |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Pulse: the frame finished |
| sclk | output | 1 | SPI clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
On every cycle, the assertions check the bus invariants: the idle bus state, SCLK only inside an asserted chip select, MOSI moving only on rising edges, received bytes reported only at falling edges, and `done` being a lone pulse that coincides with the end of the frame. The cycle counts of the clock phases, the lead and tail around chip select, the single gap after byte 0, the byte contents in both directions, the number of `tx_take` pulses and the handling of ignored starts all depend on a whole frame. Only the bench's scenarios, which time every SCLK edge against the expected schedule, can show them.

// File: rtl/spi_gap_master.sv
module spi_gap_master #(
  parameter int HALF_FAST  = 4,
  parameter int HALF_SLOW  = 8,
  parameter int GAP_CYCLES = 96,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             gap_en,
  input  logic             slow_mode,
  input  logic [7:0]       tx_data,
  output logic             tx_take,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n
);

  localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int TW   = $clog2(HMAX + GAP_CYCLES + 1);
  localparam logic [TW-1:0] HF1   = TW'(HALF_FAST - 1);
  localparam logic [TW-1:0] HS1   = TW'(HALF_SLOW - 1);
  localparam logic [TW-1:0] GAP_T = TW'(GAP_CYCLES);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_TAIL} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [CNT_W-1:0] left;
  logic [2:0]       bitn;
  logic [7:0]       tx_sh, rx_sh;
  logic             first, slow_q, gap_q;
  logic [TW-1:0]    half_m1;

  assign half_m1 = slow_q ? HS1 : HF1;
  assign busy    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tmr <= '0;
      left <= '0;
      bitn <= '0;
      tx_sh <= '0;
      rx_sh <= '0;
      first <= 1'b0;
      slow_q <= 1'b0;
      gap_q <= 1'b0;
      tx_take <= 1'b0;
      rx_data <= '0;
      rx_valid <= 1'b0;
      done <= 1'b0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      cs_n <= 1'b1;
    end else begin
      tx_take <= 1'b0;
      rx_valid <= 1'b0;
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start && byte_count != '0) begin
            cs_n <= 1'b0;
            left <= byte_count;
            slow_q <= slow_mode;
            gap_q <= gap_en && !slow_mode;
            tx_sh <= tx_data;
            tx_take <= 1'b1;
            bitn <= 3'd7;
            first <= 1'b1;
            tmr <= slow_mode ? HS1 : HF1;
            st <= S_LOW;
          end
        end
        S_LOW: begin
          if (tmr == '0) begin
            sclk <= 1'b1;
            mosi <= tx_sh[7];
            tmr <= half_m1;
            st <= S_HIGH;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_HIGH: begin
          if (tmr == '0) begin
            sclk <= 1'b0;
            rx_sh <= {rx_sh[6:0], miso};
            tmr <= half_m1;
            st <= S_LOW;
            if (bitn == 3'd0) begin
              rx_data <= {rx_sh[6:0], miso};
              rx_valid <= 1'b1;
              first <= 1'b0;
              if (left == CNT_W'(1)) begin
                st <= S_TAIL;
              end else begin
                tx_sh <= tx_data;
                tx_take <= 1'b1;
                left <= left - 1'b1;
                bitn <= 3'd7;
                if (first && gap_q) tmr <= half_m1 + GAP_T;
              end
            end else begin
              bitn <= bitn - 3'd1;
              tx_sh <= {tx_sh[6:0], 1'b0};
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_TAIL: begin
          if (tmr == '0) begin
            cs_n <= 1'b1;
            mosi <= 1'b0;
            done <= 1'b1;
            st <= S_IDLE;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !sclk));

  assert_mosi_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$rose(sclk) && !$rose(cs_n)) |-> $stable(mosi));

  assert_rx_at_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $fell(sclk));

  assert_sclk_framed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);

  assert_take_framed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> !cs_n);

  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !busy && $fell(busy)));

endmodule

// File: tb/spi_gap_master_test.sv
module spi_gap_master_test;
  localparam int CLK_P = 10;
  localparam int H_F   = 4;
  localparam int H_S   = 8;
  localparam int GAP   = 96;
  localparam int CW    = 5;

  logic clk = 0, rst_n = 0;
  logic start = 0, gap_en = 0, slow_mode = 0, miso = 0;
  logic [CW-1:0] byte_count = '0;
  logic [7:0] tx_data = '0;
  logic tx_take, rx_valid, busy, done, sclk, mosi, cs_n;
  logic [7:0] rx_data;

  spi_gap_master #(.HALF_FAST(H_F), .HALF_SLOW(H_S), .GAP_CYCLES(GAP), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .gap_en(gap_en), .slow_mode(slow_mode), .tx_data(tx_data), .tx_take(tx_take),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always #(CLK_P/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;
  logic [7:0] m_tx [32];
  logic [7:0] s_tx [32];
  logic [7:0] got_rx [32];
  logic [7:0] s_got [32];
  int rise_c [256];
  int fall_c [256];
  int nrise = 0, nfall = 0, ntake = 0, nrx = 0, done_cnt = 0, cyc = 0;
  int cs_fall_c = 0, cs_rise_c = 0;
  logic prev_sclk = 0, prev_cs = 1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (prev_cs && !cs_n) cs_fall_c = cyc;
    if (!prev_cs && cs_n) cs_rise_c = cyc;
    if (sclk && !prev_sclk && nrise < 256) begin
      rise_c[nrise] = cyc;
      miso = s_tx[nrise/8][7 - (nrise%8)];
      nrise++;
    end
    if (!sclk && prev_sclk && nfall < 256) begin
      fall_c[nfall] = cyc;
      s_got[nfall/8][7 - (nfall%8)] = mosi;
      nfall++;
    end
    if (rx_valid && nrx < 32) begin
      got_rx[nrx] = rx_data;
      nrx++;
    end
    if (tx_take) begin
      ntake++;
      tx_data = m_tx[ntake % 32];
    end
    if (done) done_cnt++;
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic frame(input int n, input bit ge, input bit sm, input bit inject);
    int h, gexp, guard, bad_hi, bad_lo, bad_rx, bad_mo, gap_seen;
    h = sm ? H_S : H_F;
    gexp = (ge && !sm && n >= 2) ? GAP : 0;
    for (int i = 0; i < 32; i++) begin
      m_tx[i] = 8'($urandom);
      s_tx[i] = 8'($urandom);
      s_got[i] = '0;
      got_rx[i] = '0;
    end
    @(negedge clk);
    nrise = 0; nfall = 0; ntake = 0; nrx = 0; done_cnt = 0;
    tx_data = m_tx[0];
    start = 1; byte_count = CW'(n); gap_en = ge; slow_mode = sm;
    @(negedge clk);
    start = 0;
    guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (inject && guard == 20) begin
        start = 1; byte_count = CW'(7);
      end else start = 0;
    end
    start = 0;
    repeat (3) @(negedge clk);
    chk(done_cnt == 1, "R10", "done pulses per frame", done_cnt, 1);
    chk(done == 0 && busy == 0 && cs_n == 1, "R10", "idle after done", int'(done), 0);
    chk(ntake == n, "R8", "tx_take pulses", ntake, n);
    chk(nrise == 8*n, "R9", "rising edges in frame", nrise, 8*n);
    chk(nrx == n, "R3", "rx_valid pulses", nrx, n);
    bad_rx = 0; bad_mo = 0;
    for (int i = 0; i < n; i++) begin
      if (got_rx[i] != s_tx[i]) bad_rx++;
      if (s_got[i] != m_tx[i]) bad_mo++;
    end
    chk(bad_rx == 0, "R3", "received bytes wrong", bad_rx, 0);
    chk(bad_mo == 0, "R2", "MOSI bytes wrong", bad_mo, 0);
    chk(rise_c[0] - cs_fall_c == h, "R4", "cs lead cycles", rise_c[0] - cs_fall_c, h);
    chk(cs_rise_c - fall_c[8*n-1] == h, "R4", "cs tail cycles", cs_rise_c - fall_c[8*n-1], h);
    bad_hi = 0; bad_lo = 0; gap_seen = h;
    for (int k = 0; k < 8*n; k++) begin
      if (fall_c[k] - rise_c[k] != h) bad_hi++;
      if (k > 0) begin
        if (k == 8) gap_seen = rise_c[8] - fall_c[7];
        else if (rise_c[k] - fall_c[k-1] != h) bad_lo++;
      end
    end
    chk(bad_hi == 0, "R5", "high phases off", bad_hi, 0);
    chk(bad_lo == 0, "R7", "non-gap low phases off", bad_lo, 0);
    if (n >= 2)
      chk(gap_seen == h + gexp, (gexp != 0) ? "R6" : "R7", "byte0-byte1 low phase",
          gap_seen, h + gexp);
    if (inject) begin
      repeat (60) @(negedge clk);
      chk(cs_n == 1 && done_cnt == 1, "R9", "no frame after busy start", done_cnt, 1);
    end
  endtask

  initial begin
    #(CLK_P*150000);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin
      m_tx[i] = '0;
      s_tx[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 0 && mosi == 0 && busy == 0 && done == 0, "R1",
        "reset bus state", int'({cs_n, sclk, mosi, busy, done}), 5'b10000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    frame(1, 1, 0, 0);
    frame(2, 1, 0, 0);
    frame(2, 0, 0, 0);
    frame(5, 1, 1, 0);
    frame(4, 1, 0, 0);
    frame(3, 1, 0, 1);
    @(negedge clk);
    start = 1; byte_count = '0;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    chk(busy == 0 && cs_n == 1, "R9", "zero count ignored", int'(busy), 0);
    for (int r = 0; r < 12; r++)
      frame(1 + int'($urandom % 12), 1'($urandom), 1'($urandom), 0);
    frame(31, 1, 0, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule